// File: doc/BRIEF.md
# Peak-Current-Mode PWM Controller Core

This block is the digital heart of a peak-current-mode step-down converter. A free-running cycle clock arrives from outside. The block synchronises it and detects its rising edge. On that edge it sets a set/reset latch whose output drives the power switch gate. An external comparator watches the inductor current against a reference. When the comparator output falls low, the latch is cleared and the switch turns off. A reset request always overrides a set request. A duty limit, learned from the measured length of the previous cycle, also forces the gate off in the last system clock before the next cycle edge.

The reference for the comparator is produced digitally. Software writes a setpoint register, and the converter's ADC delivers output-voltage samples. The block subtracts the latest sample from the setpoint and clamps a negative result to zero. On the same edge that sets the latch, this error is loaded into a down-counter. The counter then steps down by one on each tick of a prescaler, whose period software can also write. This produces a falling reference, which is the slope compensation. The counter stops at zero and does not wrap. Its value is driven onto a DAC data bus, together with a one-clock strobe whenever the value is reloaded or changes.

Top module: `cmpwm_core`

## Requirements
- R1: The cycle clock input passes through two synchroniser flops before its rising edge is detected. If `cyc_clk_i` is sampled low at one clock edge and high at the next (edge k), and the comparator allows it, `gate_o` is high after edge k+2.
- R2: A cycle clock held high, or held low, never sets the gate again. Only a low-to-high transition sets it.
- R3: `cmp_i` passes through two synchroniser flops. If it is sampled low at edge k, `gate_o` is low after edge k+2, and it stays low for as long as the synchronised comparator level is low.
- R4: When a set (a detected cycle edge) and a reset (a low synchronised comparator, or the duty limit) occur in the same clock, the reset wins and the gate stays low.
- R5: When `sp_we_i` is high at a clock edge, `sp_data_i` is stored as the setpoint. When `adc_valid_i` is high at a clock edge, `adc_data_i` is stored as the voltage sample. When `slope_we_i` is high at a clock edge, `slope_data_i` is stored as the prescaler period.
- R6: The error equals the setpoint minus the sample when the setpoint is greater than the sample, and equals 0 otherwise.
- R7: The down-counter is loaded with the error on the same clock edge that sets the latch. `dac_data_o` shows the loaded value from that edge on.
- R8: Between reloads, the counter decreases by exactly 1 once every slope+1 clocks, where slope is the stored prescaler period (0 means every clock). Once it reaches 0, it stays at 0.
- R9: `dac_strobe_o` is high for the single clock after each reload and after each decrement, and is low otherwise. Every change of `dac_data_o` is accompanied by the strobe.
- R10: The block measures the clock count P between two consecutive detected cycle edges. Once it has done so, the gate is forced low during the clock that precedes the next detected edge, that is, P-1 clocks after the previous one. Before the first such measurement, no duty limit applies.
- R11: While `rst_n` is low, and after it is released, the gate, DAC data, strobe, setpoint, sample and slope registers are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_clk_i | input | 1 | Free-running switching-cycle clock (asynchronous) |
| cmp_i | input | 1 | Current-sense comparator; low means the current has reached the reference |
| sp_we_i | input | 1 | Setpoint write enable |
| sp_data_i | input | 8 | Setpoint write data |
| adc_valid_i | input | 1 | ADC sample valid |
| adc_data_i | input | 8 | Raw ADC output-voltage sample |
| slope_we_i | input | 1 | Slope prescaler write enable |
| slope_data_i | input | 8 | Slope prescaler period (clocks per step minus one) |
| gate_o | output | 1 | Power switch gate drive |
| dac_data_o | output | 8 | Reference value to the DAC |
| dac_strobe_o | output | 1 | DAC update strobe |

## Verification
If the latch state is wrong, `gate_o` is wrong within two clocks of the synchronised cause. If the counter or prescaler state is wrong, `dac_data_o` diverges at the next tick, and at the latest at the next cycle edge. If the measured period is wrong, the forced-off clock lands in the wrong place within one switching cycle. A reference model in the bench follows every clock, so any of these faults shows up within a few cycles. The comparator is modelled as a current ramp that crosses the DAC value, which closes the loop.

// File: rtl/cmpwm_pkg.sv
package cmpwm_pkg;
    // Latch action selected each clock
    typedef enum logic [1:0] {
        LA_HOLD  = 2'd0,
        LA_SET   = 2'd1,
        LA_CLEAR = 2'd2
    } latch_act_e;

    localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/cmpwm_sync.sv
module cmpwm_sync #(
    parameter int unsigned STAGES = 2,
    parameter bit          FALL   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic sync_o,
    output logic edge_o
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], d_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sync_o = sh_q[STAGES-1];

    generate
        if (FALL) begin : g_fall
            assign edge_o = ~sh_q[STAGES-1] & sh_q[STAGES];
        end else begin : g_rise
            assign edge_o = sh_q[STAGES-1] & ~sh_q[STAGES];
        end
    endgenerate

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o); // R1
endmodule

// File: rtl/cmpwm_err.sv
module cmpwm_err #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sp_we_i,
    input  logic [DW-1:0] sp_data_i,
    input  logic          adc_valid_i,
    input  logic [DW-1:0] adc_data_i,
    output logic [DW-1:0] err_o
);
    typedef struct packed {
        logic [DW-1:0] sp;
        logic [DW-1:0] smp;
    } err_st_t;

    err_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sp_we_i)     st_d.sp  = sp_data_i;
        if (adc_valid_i) st_d.smp = adc_data_i;
        err_o = (st_q.sp > st_q.smp) ? (st_q.sp - st_q.smp) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_ERR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_valid_i && sp_we_i && adc_data_i >= sp_data_i) |=> (err_o == '0)); // R6
endmodule

// File: rtl/cmpwm_ramp.sv
module cmpwm_ramp #(
    parameter int unsigned DW = 8,
    parameter int unsigned PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slope_we_i,
    input  logic [PW-1:0] slope_data_i,
    input  logic          load_i,
    input  logic [DW-1:0] err_i,
    output logic [DW-1:0] dac_data_o,
    output logic          dac_strobe_o
);
    typedef struct packed {
        logic [PW-1:0] slope;
        logic [PW-1:0] pre;
        logic [DW-1:0] ctr;
        logic          stb;
    } ramp_st_t;

    ramp_st_t st_d, st_q;
    logic     tick;

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        tick     = (st_q.pre == st_q.slope);
        if (load_i) begin
            st_d.ctr = err_i;
            st_d.pre = '0;
            st_d.stb = 1'b1;
        end else if (tick) begin
            st_d.pre = '0;
            if (st_q.ctr != '0) begin
                st_d.ctr = st_q.ctr - 1'b1;
                st_d.stb = 1'b1;
            end
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
        if (slope_we_i) st_d.slope = slope_data_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dac_data_o   = st_q.ctr;
    assign dac_strobe_o = st_q.stb;

    AST_LOAD_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (dac_data_o == $past(err_i))); // R7
    AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && dac_data_o == '0) |=> (dac_data_o == '0)); // R8
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> (dac_data_o == $past(dac_data_o) || dac_data_o == $past(dac_data_o) - 1'b1)); // R8
    AST_STROBE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_data_o != $past(dac_data_o)) |-> dac_strobe_o); // R9
endmodule

// File: rtl/cmpwm_core.sv
module cmpwm_core #(
    parameter int unsigned DW = 8,
    parameter int unsigned PW = 8,
    parameter int unsigned CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cyc_clk_i,
    input  logic          cmp_i,
    input  logic          sp_we_i,
    input  logic [DW-1:0] sp_data_i,
    input  logic          adc_valid_i,
    input  logic [DW-1:0] adc_data_i,
    input  logic          slope_we_i,
    input  logic [PW-1:0] slope_data_i,
    output logic          gate_o,
    output logic [DW-1:0] dac_data_o,
    output logic          dac_strobe_o
);
    import cmpwm_pkg::*;

    localparam logic [CW-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic          gate;
        logic          seen;
        logic [CW-1:0] cnt;
        logic [CW-1:0] per;
    } core_st_t;

    core_st_t      st_d, st_q;
    latch_act_e    act;
    logic          cyc_rise, cyc_lvl;
    logic          cmp_lvl, cmp_fall;
    logic          cmp_low, duty_hit;
    logic [DW-1:0] err;

    cmpwm_sync #(.STAGES(SYNC_DEPTH), .FALL(1'b0)) u_cyc_sync (
        .clk(clk), .rst_n(rst_n), .d_i(cyc_clk_i), .sync_o(cyc_lvl), .edge_o(cyc_rise));

    cmpwm_sync #(.STAGES(SYNC_DEPTH), .FALL(1'b1)) u_cmp_sync (
        .clk(clk), .rst_n(rst_n), .d_i(cmp_i), .sync_o(cmp_lvl), .edge_o(cmp_fall));

    cmpwm_err #(.DW(DW)) u_err (
        .clk(clk), .rst_n(rst_n), .sp_we_i(sp_we_i), .sp_data_i(sp_data_i),
        .adc_valid_i(adc_valid_i), .adc_data_i(adc_data_i), .err_o(err));

    cmpwm_ramp #(.DW(DW), .PW(PW)) u_ramp (
        .clk(clk), .rst_n(rst_n), .slope_we_i(slope_we_i), .slope_data_i(slope_data_i),
        .load_i(cyc_rise), .err_i(err), .dac_data_o(dac_data_o), .dac_strobe_o(dac_strobe_o));

    always_comb begin
        st_d     = st_q;
        cmp_low  = ~cmp_lvl;
        duty_hit = (st_q.per >= CW'(2)) && (st_q.cnt == st_q.per - CW'(2));

        if (cmp_low || duty_hit) act = LA_CLEAR;
        else if (cyc_rise)       act = LA_SET;
        else                     act = LA_HOLD;

        case (act)
            LA_SET:   st_d.gate = 1'b1;
            LA_CLEAR: st_d.gate = 1'b0;
            default:  st_d.gate = st_q.gate;
        endcase

        if (cyc_rise) begin
            if (st_q.seen) st_d.per = (st_q.cnt == CNT_MAX) ? st_q.cnt : st_q.cnt + 1'b1;
            st_d.seen = 1'b1;
            st_d.cnt  = '0;
        end else if (st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gate_o = st_q.gate;

    AST_CMP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_fall |=> !gate_o); // R3
    AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_rise && cmp_low) |=> !gate_o); // R4
    AST_DUTY_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        duty_hit |=> !gate_o); // R10
    AST_SET_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_o) |-> ($past(cyc_rise) && $past(cyc_lvl))); // R1
endmodule

// File: tb/cmpwm_core_test.sv
module cmpwm_core_test;
    localparam int CMAX = 1023;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_clk_i = 1'b0;
    logic       cmp_i = 1'b1;
    logic       sp_we_i = 1'b0;
    logic [7:0] sp_data_i = '0;
    logic       adc_valid_i = 1'b0;
    logic [7:0] adc_data_i = '0;
    logic       slope_we_i = 1'b0;
    logic [7:0] slope_data_i = '0;
    logic       gate_o;
    logic [7:0] dac_data_o;
    logic       dac_strobe_o;

    int n_checks = 0, n_fail = 0, n_clk = 0;
    bit done = 0;

    // stimulus controls
    int  cyc_per = 40, cyc_cnt = 0;
    bit  cyc_run = 0;
    bit  cmp_force_hi = 0, cmp_force_lo = 0;
    int  current = 0, rate = 3;
    int  gate_hi_cnt = 0, gate_lo_cnt = 0;

    // reference model state
    int  m_gate, m_seen, m_cnt, m_per, m_ctr, m_pre, m_stb, m_sp, m_adc, m_slope;
    int  h0, h1, h2, c1, c2;

    cmpwm_core uut (
        .clk(clk), .rst_n(rst_n), .cyc_clk_i(cyc_clk_i), .cmp_i(cmp_i),
        .sp_we_i(sp_we_i), .sp_data_i(sp_data_i), .adc_valid_i(adc_valid_i),
        .adc_data_i(adc_data_i), .slope_we_i(slope_we_i), .slope_data_i(slope_data_i),
        .gate_o(gate_o), .dac_data_o(dac_data_o), .dac_strobe_o(dac_strobe_o));

    always #5 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at clk %0d", tag, act, exp, n_clk);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // behavioural reference model
    always @(posedge clk) begin
        int rise, clow, maxd, errv, ngate;
        n_clk++;
        if (!rst_n) begin
            m_gate = 0; m_seen = 0; m_cnt = 0; m_per = 0; m_ctr = 0; m_pre = 0;
            m_stb = 0; m_sp = 0; m_adc = 0; m_slope = 0;
            h0 = 0; h1 = 0; h2 = 0; c1 = 0; c2 = 0;
        end else begin
            rise  = (h1 == 1 && h2 == 0);
            clow  = (c2 == 0);
            maxd  = (m_per >= 2 && m_cnt == m_per - 2);
            errv  = (m_sp > m_adc) ? m_sp - m_adc : 0;
            ngate = (clow || maxd) ? 0 : (rise ? 1 : m_gate);
            if (rise) begin
                if (m_seen) m_per = (m_cnt == CMAX) ? m_cnt : m_cnt + 1;
                m_seen = 1;
                m_cnt  = 0;
                m_ctr  = errv; m_pre = 0; m_stb = 1;
            end else begin
                if (m_cnt != CMAX) m_cnt++;
                if (m_pre == m_slope) begin
                    m_pre = 0;
                    if (m_ctr > 0) begin m_ctr--; m_stb = 1; end
                    else m_stb = 0;
                end else begin
                    m_pre++; m_stb = 0;
                end
            end
            if (sp_we_i)     m_sp    = sp_data_i;
            if (adc_valid_i) m_adc   = adc_data_i;
            if (slope_we_i)  m_slope = slope_data_i;
            h2 = h1; h1 = h0; h0 = cyc_clk_i;
            c2 = c1; c1 = cmp_i;
            m_gate = ngate;
        end
    end

    // compare, plant model and cycle clock generation
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R1/R2/R3/R4/R10 gate", gate_o, m_gate);
            check("R5 R6 R7 R8 dac", dac_data_o, m_ctr);
            check("R9 strobe", dac_strobe_o, m_stb);
            if (gate_o) gate_hi_cnt++; else gate_lo_cnt++;
        end
        if (gate_o) current = current + rate;
        else current = (current > rate) ? current - rate : 0;
        if (cmp_force_hi)      cmp_i = 1'b1;
        else if (cmp_force_lo) cmp_i = 1'b0;
        else                   cmp_i = (current < dac_data_o);
        if (cyc_run) begin
            cyc_clk_i = (cyc_cnt < cyc_per / 2);
            cyc_cnt = (cyc_cnt + 1) % cyc_per;
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (n_clk > 150000 && !done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<=%0d", n_clk, 150000);
            finish_run();
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int sp, input int adc, input int slope);
        @(negedge clk);
        sp_we_i = 1; sp_data_i = 8'(sp);
        adc_valid_i = 1; adc_data_i = 8'(adc);
        slope_we_i = 1; slope_data_i = 8'(slope);
        @(negedge clk);
        sp_we_i = 0; adc_valid_i = 0; slope_we_i = 0;
    endtask

    initial begin
        run(5);
        // R11: reset state
        check("R11 gate reset", gate_o, 0);
        check("R11 dac reset", dac_data_o, 0);
        check("R11 strobe reset", dac_strobe_o, 0);
        rst_n = 1;
        run(3);
        check("R11 dac after release", dac_data_o, 0);

        // R1 latency: a clean edge with comparator high
        cmp_force_hi = 1;
        @(negedge clk); cyc_clk_i = 1;      // sampled high at next edge k
        @(negedge clk);                      // after k
        @(negedge clk);                      // after k+1
        check("R1 gate low before k+2", gate_o, 0);
        @(negedge clk);                      // after k+2
        check("R1 gate high after k+2", gate_o, 1);
        run(20);
        check("R2 gate held without new edge", gate_o, 1);
        cmp_force_hi = 0; cmp_force_lo = 1;
        run(3);
        check("R3 gate cleared by comparator", gate_o, 0);
        cmp_force_lo = 0; cyc_clk_i = 0;

        // main loop: several setpoint / sample / slope patterns
        wr(120, 40, 1);
        cyc_cnt = 0; cyc_run = 1;
        run(400);
        wr(60, 200, 2);                      // R6 saturation to 0
        run(200);
        wr(255, 0, 0);
        run(300);
        wr(90, 89, 5);
        run(200);

        // R10: comparator never trips, duty limit must cut the gate
        wr(200, 10, 3);
        cmp_force_hi = 1;
        gate_lo_cnt = 0;
        run(400);
        check("R10 gate forced low each cycle", (gate_lo_cnt >= 9) ? 1 : 0, 1);

        // R4: comparator held low through edges, gate never sets
        cmp_force_hi = 0; cmp_force_lo = 1;
        run(5);
        gate_hi_cnt = 0;
        run(200);
        check("R4 reset beats set", gate_hi_cnt, 0);
        cmp_force_lo = 0;

        // shorter period, then cycle clock stalled high (R2)
        cyc_per = 25;
        run(300);
        cyc_run = 0; cyc_clk_i = 1;
        run(150);
        cyc_run = 1; cyc_cnt = 0;
        run(200);

        done = 1;
        finish_run();
    end
endmodule